// File: doc/BRIEF.md
# Reset and Wake Event Generator

This block produces the system power-on reset and the processor reset for a power-management controller, filters the three mechanical inputs (wake button, hot-reset button and battery-cover switch), and turns their filtered transitions into one-cycle event pulses and sticky, maskable interrupt flags. The power-on reset follows the LDO1 power-good flag with a fixed hold-off. A hot-reset press gives the processor a fixed-length reset pulse, but only when the core rail reports that it is in regulation.

Each raw pin first passes a two-flop synchronizer and then a debouncer, which changes its filtered level only after the synchronized value has differed from it for a set number of consecutive clocks. The wake button is active high. The hot-reset and cover pins are active low, and their idle level is high. All timer and filter lengths are parameters counted in clock cycles. An interrupt-status read path lies outside this block. Software reaches the block only through a write-one-to-clear input and a mask input.

Top module: `rwe_reset_wake_gen`

## Requirements
- R1: After `ldo_good` rises, `por_n` stays 0 and goes to 1 exactly POR_CYCLES clock edges later, counting the first edge that samples `ldo_good` high.
- R2: When `ldo_good` is sampled low, `por_n` is 0 after that edge. The POR_CYCLES count restarts once `ldo_good` returns high.
- R3: A hot-reset event (`hrst_evt`) seen while `core_ok` is 1 and `por_n` is 1 drives `cpu_rst_n` low for exactly MPU_CYCLES cycles, starting the cycle after the event. With `core_ok` at 0 the event leaves `cpu_rst_n` high.
- R4: `cpu_rst_n` is 0 in every cycle in which `por_n` is 0.
- R5: A debounced level changes only after the synchronized raw level has differed from it for DEB_CYCLES consecutive edges. The first event pulse is visible DEB_CYCLES+2 edges after the raw change. Shorter pulses on any pin have no effect.
- R6: `pb_evt` pulses for one cycle on a debounced rise of `pb_raw`. `hrst_evt` pulses on a debounced fall of `hrst_raw_n`. `cover_evt` pulses on a debounced fall of `cover_raw`.
- R7: `irq_stat` bit 0 is set by `pb_evt` and bit 1 by `cover_evt`, one edge after the pulse. Each bit stays set until a 1 is written to the same bit of `irq_clr`. A set and a clear in the same cycle leave the bit set.
- R8: `irq` is the OR of the `irq_stat` bits whose `irq_mask` bit is 0 (mask bit 1 hides the source). It is registered, so it reflects a mask or status change after one edge.
- R9: During reset, `por_n`, `cpu_rst_n`, `irq` and all event pulses are 0, and `irq_stat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_raw | input | 1 | Raw wake push-button, active high |
| hrst_raw_n | input | 1 | Raw hot-reset button, active low |
| cover_raw | input | 1 | Raw battery-cover switch, 1 = cover in place |
| ldo_good | input | 1 | LDO1 output in regulation |
| core_ok | input | 1 | Core rail in regulation |
| irq_mask | input | 2 | Interrupt masks, bit 0 button, bit 1 cover, 1 = masked |
| irq_clr | input | 2 | Write-one-to-clear strobes for irq_stat |
| por_n | output | 1 | Power-on reset, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| pb_evt | output | 1 | One-cycle pulse on debounced button press |
| hrst_evt | output | 1 | One-cycle pulse on debounced hot-reset press |
| cover_evt | output | 1 | One-cycle pulse on debounced cover removal |
| irq_stat | output | 2 | Sticky interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are a set and a clear of a status bit in the same cycle, and a raw pulse that lasts exactly one cycle less than, or exactly as long as, the debounce length. For the first, the bench watches for the event pulse and drives the clear strobe during that same cycle. For the second, it sweeps the pulse width on every pin from one cycle up to one cycle beyond the filter length and counts event pulses in a fixed window. The hot-reset sweep runs with the core rail reported out of regulation, so the same stimulus also shows that no processor reset pulse is produced in that state.

// File: rtl/rwe_pkg.sv
package rwe_pkg;
    localparam int NUM_PINS  = 3;
    localparam int PIN_PB    = 0;
    localparam int PIN_HRST  = 1;
    localparam int PIN_COVER = 2;
    // idle levels of the pins: button low, hot-reset high, cover high
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 3'b110;

    localparam int NUM_IRQ   = 2;
    localparam int IRQ_PB    = 0;
    localparam int IRQ_COVER = 1;
endpackage

// File: rtl/rwe_debounce.sv
module rwe_debounce #(
    parameter int   DEB_CYCLES = 16,
    parameter logic IDLE_LVL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          level;
        logic          rise;
        logic          fall;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], raw_i};
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (st_q.sync[1] != st_q.level) begin
            if (st_q.cnt == CW'(DEB_CYCLES - 1)) begin
                st_d.level = st_q.sync[1];
                st_d.cnt   = '0;
                st_d.rise  = st_q.sync[1];
                st_d.fall  = ~st_q.sync[1];
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync  <= {IDLE_LVL, IDLE_LVL};
            st_q.level <= IDLE_LVL;
            st_q.rise  <= 1'b0;
            st_q.fall  <= 1'b0;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign rise_o  = st_q.rise;
    assign fall_o  = st_q.fall;

    AST_DEB_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.level) |-> $past(st_q.cnt) == CW'(DEB_CYCLES - 1)); // R5
    AST_DEB_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.rise && st_q.fall)); // R6
endmodule

// File: rtl/rwe_reset_ctrl.sv
module rwe_reset_ctrl #(
    parameter int POR_CYCLES = 1000,
    parameter int MPU_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ldo_good,
    input  logic core_ok,
    input  logic hrst_evt,
    output logic por_n,
    output logic cpu_rst_n
);
    localparam int PCW = $clog2(POR_CYCLES + 1);
    localparam int MCW = $clog2(MPU_CYCLES + 1);

    typedef struct packed {
        logic           por;
        logic           cpu;
        logic [PCW-1:0] pcnt;
        logic [MCW-1:0] mcnt;
    } rst_t;

    rst_t st_d, st_q;
    logic trig;

    always_comb begin
        st_d = st_q;
        if (!ldo_good) begin
            st_d.por  = 1'b0;
            st_d.pcnt = '0;
        end else if (!st_q.por) begin
            if (st_q.pcnt == PCW'(POR_CYCLES - 1)) begin
                st_d.por  = 1'b1;
                st_d.pcnt = '0;
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
        end

        trig = hrst_evt && core_ok && st_q.por;
        if (trig) begin
            st_d.mcnt = MCW'(MPU_CYCLES);
        end else if (st_q.mcnt != '0) begin
            st_d.mcnt = st_q.mcnt - 1'b1;
        end
        if (!st_d.por) begin
            st_d.mcnt = '0;
        end
        st_d.cpu = st_d.por && (st_d.mcnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign por_n     = st_q.por;
    assign cpu_rst_n = st_q.cpu;

    AST_POR_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.por) |-> $past(st_q.pcnt) == PCW'(POR_CYCLES - 1)); // R1
    AST_POR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !ldo_good |=> !por_n); // R2
    AST_PULSE_NEEDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_rst_n) && por_n) |-> $past(core_ok)); // R3
    AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_rst_n) && $past(por_n)) |-> $past(st_q.mcnt) == MCW'(1)); // R3
    AST_CPU_UNDER_POR: assert property (@(posedge clk) disable iff (!rst_n)
        !por_n |-> !cpu_rst_n); // R4
endmodule

// File: rtl/rwe_irq_ctrl.sv
module rwe_irq_ctrl
    import rwe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] set_i,
    input  logic [NUM_IRQ-1:0] mask_i,
    input  logic [NUM_IRQ-1:0] clr_i,
    output logic [NUM_IRQ-1:0] stat_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] stat;
        logic               irq;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr_i) | set_i;
        st_d.irq  = |(st_d.stat & ~mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign irq_o  = st_q.irq;

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_o) & ~$past(clr_i) & ~stat_o) == '0)); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(set_i) & ~stat_o)) == '0)); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_o) == '0 && $past(set_i) == '0) |-> !irq_o); // R8
endmodule

// File: rtl/rwe_reset_wake_gen.sv
module rwe_reset_wake_gen
    import rwe_pkg::*;
#(
    parameter int DEB_CYCLES = 16,
    parameter int POR_CYCLES = 1000,
    parameter int MPU_CYCLES = 100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pb_raw,
    input  logic               hrst_raw_n,
    input  logic               cover_raw,
    input  logic               ldo_good,
    input  logic               core_ok,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic [NUM_IRQ-1:0] irq_clr,
    output logic               por_n,
    output logic               cpu_rst_n,
    output logic               pb_evt,
    output logic               hrst_evt,
    output logic               cover_evt,
    output logic [NUM_IRQ-1:0] irq_stat,
    output logic               irq
);
    logic [NUM_PINS-1:0] raw_vec;
    logic [NUM_PINS-1:0] lvl_vec;
    logic [NUM_PINS-1:0] rise_vec;
    logic [NUM_PINS-1:0] fall_vec;
    logic [NUM_IRQ-1:0]  irq_set;

    assign raw_vec[PIN_PB]    = pb_raw;
    assign raw_vec[PIN_HRST]  = hrst_raw_n;
    assign raw_vec[PIN_COVER] = cover_raw;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        rwe_debounce #(
            .DEB_CYCLES (DEB_CYCLES),
            .IDLE_LVL   (PIN_IDLE[g])
        ) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_vec[g]),
            .level_o (lvl_vec[g]),
            .rise_o  (rise_vec[g]),
            .fall_o  (fall_vec[g])
        );
    end

    assign pb_evt    = rise_vec[PIN_PB];
    assign hrst_evt  = fall_vec[PIN_HRST];
    assign cover_evt = fall_vec[PIN_COVER];

    rwe_reset_ctrl #(
        .POR_CYCLES (POR_CYCLES),
        .MPU_CYCLES (MPU_CYCLES)
    ) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .ldo_good  (ldo_good),
        .core_ok   (core_ok),
        .hrst_evt  (hrst_evt),
        .por_n     (por_n),
        .cpu_rst_n (cpu_rst_n)
    );

    assign irq_set[IRQ_PB]    = pb_evt;
    assign irq_set[IRQ_COVER] = cover_evt;

    rwe_irq_ctrl u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_set),
        .mask_i (irq_mask),
        .clr_i  (irq_clr),
        .stat_o (irq_stat),
        .irq_o  (irq)
    );

    AST_EVT_LEVEL_PB: assert property (@(posedge clk) disable iff (!rst_n)
        pb_evt |-> lvl_vec[PIN_PB]); // R6
    AST_EVT_LEVEL_COVER: assert property (@(posedge clk) disable iff (!rst_n)
        cover_evt |-> !lvl_vec[PIN_COVER]); // R6
endmodule

// File: tb/rwe_reset_wake_gen_tb.sv
module rwe_reset_wake_gen_tb;
    localparam int DEB = 3;
    localparam int POR = 8;
    localparam int MPU = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pb_raw = 1'b0, hrst_raw_n = 1'b1, cover_raw = 1'b1;
    logic ldo_good = 1'b0, core_ok = 1'b0;
    logic [1:0] irq_mask = 2'b00, irq_clr = 2'b00;
    logic por_n, cpu_rst_n, pb_evt, hrst_evt, cover_evt, irq;
    logic [1:0] irq_stat;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rwe_reset_wake_gen #(
        .DEB_CYCLES (DEB),
        .POR_CYCLES (POR),
        .MPU_CYCLES (MPU)
    ) u_dut (
        .clk, .rst_n, .pb_raw, .hrst_raw_n, .cover_raw, .ldo_good, .core_ok,
        .irq_mask, .irq_clr, .por_n, .cpu_rst_n, .pb_evt, .hrst_evt,
        .cover_evt, .irq_stat, .irq
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_por(input string req);
        int n = 0;
        do begin
            tick();
            n++;
        end while (!por_n && n < 100);
        chk(req, n, POR);
    endtask

    // drive pin p to its active level for len cycles, count its event pulses
    task automatic glitch(input int p, input int len, output int evts, output int cpu_low);
        evts = 0;
        cpu_low = 0;
        for (int i = 0; i < len + 20; i++) begin
            if (i < len) begin
                if (p == 0) pb_raw = 1'b1;
                if (p == 1) hrst_raw_n = 1'b0;
                if (p == 2) cover_raw = 1'b0;
            end else begin
                pb_raw = 1'b0;
                hrst_raw_n = 1'b1;
                cover_raw = 1'b1;
            end
            tick();
            if (p == 0 && pb_evt) evts++;
            if (p == 1 && hrst_evt) evts++;
            if (p == 2 && cover_evt) evts++;
            if (!cpu_rst_n) cpu_low++;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int ev, cl, n;
        // R9 reset state
        repeat (3) tick();
        chk("R9 por_n", por_n, 0);
        chk("R9 cpu_rst_n", cpu_rst_n, 0);
        chk("R9 irq", irq, 0);
        chk("R9 irq_stat", irq_stat, 0);
        chk("R9 events", pb_evt + hrst_evt + cover_evt, 0);
        rst_n = 1'b1;
        repeat (3) tick();
        chk("R1 por low while ldo bad", por_n, 0);
        chk("R4 cpu low while por low", cpu_rst_n, 0);

        // R1 power-up hold-off
        ldo_good = 1'b1;
        count_por("R1 holdoff");
        chk("R4 cpu follows por up", cpu_rst_n, 1);

        // R2 drops of several lengths
        for (int len = 1; len <= 3; len++) begin
            ldo_good = 1'b0;
            tick();
            chk("R2 por drops", por_n, 0);
            chk("R4 cpu under por", cpu_rst_n, 0);
            for (int i = 1; i < len; i++) tick();
            ldo_good = 1'b1;
            count_por("R2 re-arm");
        end
        tick();

        // R5 exact latency
        pb_raw = 1'b1;
        n = 0;
        do begin
            tick();
            n++;
        end while (!pb_evt && n < 50);
        chk("R5 latency", n, DEB + 2);
        tick();
        chk("R6 pb_evt single cycle", pb_evt, 0);
        pb_raw = 1'b0;
        repeat (10) tick();

        // R5 R6 pulse-width sweep on every pin, core out of regulation
        core_ok = 1'b0;
        for (int p = 0; p < 3; p++) begin
            for (int len = 1; len <= DEB + 1; len++) begin
                glitch(p, len, ev, cl);
                chk($sformatf("R5 R6 pin%0d width%0d", p, len), ev, (len >= DEB) ? 1 : 0);
                if (p == 1) chk("R3 no pulse without core", cl, 0);
            end
        end

        // R3 hot reset with core in regulation
        core_ok = 1'b1;
        tick();
        glitch(1, 12, ev, cl);
        chk("R3 hot-reset event", ev, 1);
        chk("R3 pulse length", cl, MPU);
        hrst_raw_n = 1'b0;
        n = 0;
        do begin
            tick();
            n++;
        end while (cpu_rst_n && n < 50);
        chk("R3 pulse start", n, DEB + 3);
        hrst_raw_n = 1'b1;
        repeat (20) tick();

        // R7 R8 interrupts
        irq_clr = 2'b11;
        tick();
        irq_clr = 2'b00;
        irq_mask = 2'b00;
        tick();
        chk("R7 cleared", irq_stat, 0);
        chk("R8 no request", irq, 0);
        glitch(0, 6, ev, cl);
        chk("R7 button sets bit0", irq_stat, 1);
        for (int m = 0; m < 4; m++) begin
            irq_mask = 2'(m);
            tick();
            chk($sformatf("R8 stat1 mask%0d", m), irq, ((1 & ~m) != 0) ? 1 : 0);
        end
        glitch(2, 6, ev, cl);
        chk("R7 cover sets bit1, sticky bit0", irq_stat, 3);
        for (int m = 0; m < 4; m++) begin
            irq_mask = 2'(m);
            tick();
            chk($sformatf("R8 stat3 mask%0d", m), irq, ((3 & ~m) != 0) ? 1 : 0);
        end
        irq_mask = 2'b00;
        irq_clr = 2'b01;
        tick();
        irq_clr = 2'b00;
        chk("R7 clear bit0 only", irq_stat, 2);
        tick();
        chk("R8 request from bit1", irq, 1);
        irq_clr = 2'b10;
        tick();
        irq_clr = 2'b00;
        tick();
        chk("R8 request drops", irq, 0);

        // R7 set wins over clear in the same cycle
        pb_raw = 1'b1;
        n = 0;
        do begin
            tick();
            n++;
        end while (!pb_evt && n < 50);
        irq_clr = 2'b01;
        tick();
        irq_clr = 2'b00;
        chk("R7 set wins", irq_stat, 1);
        pb_raw = 1'b0;
        repeat (10) tick();
        chk("R7 still set", irq_stat, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule